// File: doc/BRIEF.md
# Buck Converter PWM/PFM Mode Arbiter

This block decides, once per switching period, whether a synchronous buck converter runs with fixed-frequency pulse-width modulation or in light-load hysteretic (pulse-frequency) operation. All analog parts stay outside the block and reach it only as digital flags. These are the switching-period tick and the switch-node polarity. Three output comparators report that the output has dipped under the hysteretic regulation level (about 20 mV under the reference), that it is under the lower hysteretic threshold (about 10 mV under) and that it is over the upper hysteretic threshold (about 5 mV over). The block also receives the high-side request of the external modulator, a forced-PWM input and a soft-start completion flag.

A run counter debounces mode changes. The block moves to hysteretic operation only after a fixed number of consecutive positive switch-node samples, which means reverse inductor current. It moves back to PWM after the same number of consecutive negative samples. An output dip skips the counter and returns the converter to PWM at the next tick. Forced-PWM and an unfinished soft-start both lock hysteretic operation out. In hysteretic mode the block makes the high-side pulses from the comparators and runs the low-side switch as a rectifier that turns off when its current reverses. Both drive requests are blanked for one switching period after the block enters hysteretic mode.

Top module: `pwm_pfm_arbiter`

## Requirements
- R1: After reset the block is in PWM mode (`hyst_mode` = 0) with the run counter cleared, and `both_off` is 0.
- R2: With `ss_done` = 1 and `force_pwm` = 0, PWM mode changes to hysteretic at the clock edge of the RUN_LEN-th consecutive tick that samples `sw_pos` = 1. After RUN_LEN-1 such ticks the block is still in PWM mode.
- R3: In hysteretic mode, the block returns to PWM at the edge of the RUN_LEN-th consecutive tick that samples `sw_pos` = 0.
- R4: A tick that samples the polarity opposite to the one being counted clears the run count, so the next change again needs RUN_LEN fresh consecutive samples.
- R5: In hysteretic mode, a tick with `out_dip` = 1 returns the block to PWM at that tick's edge. `out_dip` has no effect on the mode in a clock without a tick.
- R6: While `force_pwm` = 1 the block never enters hysteretic mode. If `force_pwm` is high at a tick while the block is in hysteretic mode, the block returns to PWM at that tick.
- R7: While `ss_done` = 0 the block never enters hysteretic mode. If `ss_done` is low at a tick while the block is in hysteretic mode, the block returns to PWM at that tick.
- R8: At the change into hysteretic mode `both_off` goes to 1 for one switching period, up to the next tick edge. During that period `hs_req` and `ls_req` are both 0.
- R9: In hysteretic mode, `hs_req` goes to 1 one clock after `out_low` = 1 is seen and goes back to 0 one clock after `out_high` = 1 is seen.
- R10: In hysteretic mode, `ls_req` is 1 after a high-side pulse ends, for as long as `sw_pos` = 0. It drops in the same cycle that `sw_pos` reads 1, and it stays 0 until the next high-side pulse.
- R11: In PWM mode outside blanking, `hs_req` = `pwm_req` and `ls_req` = !`pwm_req`. Switch-node values in clocks without a tick do not affect the run count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Switching-period sample strobe, high at the end of low-side conduction |
| sw_pos | input | 1 | Switch-node polarity, 1 = positive (reverse inductor current) |
| out_dip | input | 1 | Output below the hysteretic regulation level |
| out_low | input | 1 | Output below the lower hysteretic threshold |
| out_high | input | 1 | Output above the upper hysteretic threshold |
| force_pwm | input | 1 | Lock out hysteretic operation |
| ss_done | input | 1 | Soft-start has completed |
| pwm_req | input | 1 | High-side request from the PWM modulator |
| hyst_mode | output | 1 | 1 = hysteretic mode, 0 = PWM mode |
| hs_req | output | 1 | High-side gate request |
| ls_req | output | 1 | Low-side gate request |
| both_off | output | 1 | Transition blanking strobe |

## Verification
The bench builds the block with the default RUN_LEN of 8. At this value the boundary between seven and eight consecutive samples is checked in both directions. An opposite-polarity sample at position eight shows that the count restarts, and a gap of non-tick clocks inside a run shows that the count is kept. The same setting leaves room to enter and leave hysteretic mode by each route (run counter, dip, forced-PWM, soft-start) within one short stimulus table plus directed sequences.

// File: rtl/pwm_pfm_arbiter.sv
module pwm_pfm_arbiter #(
  parameter int RUN_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sw_pos,
  input  logic out_dip,
  input  logic out_low,
  input  logic out_high,
  input  logic force_pwm,
  input  logic ss_done,
  input  logic pwm_req,
  output logic hyst_mode,
  output logic hs_req,
  output logic ls_req,
  output logic both_off
);

  localparam int CNT_W = (RUN_LEN > 2) ? $clog2(RUN_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_LEN - 1);

  logic [CNT_W-1:0] run_cnt, run_cnt_nxt;
  logic mode_nxt, blank, blank_nxt;
  logic pulse_on, rect_arm;

  wire hyst_ok   = ss_done & ~force_pwm;
  wire want_flip = hyst_mode ? ~sw_pos : (sw_pos & hyst_ok);
  wire run_hit   = (run_cnt == LAST);

  always_comb begin
    mode_nxt    = hyst_mode;
    run_cnt_nxt = run_cnt;
    blank_nxt   = blank;
    if (tick) begin
      blank_nxt = 1'b0;
      if (hyst_mode && (out_dip || !hyst_ok)) begin
        mode_nxt    = 1'b0;
        run_cnt_nxt = '0;
      end else if (want_flip) begin
        if (run_hit) begin
          mode_nxt    = ~hyst_mode;
          run_cnt_nxt = '0;
          blank_nxt   = ~hyst_mode;
        end else begin
          run_cnt_nxt = run_cnt + 1'b1;
        end
      end else begin
        run_cnt_nxt = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hyst_mode <= 1'b0;
      run_cnt   <= '0;
      blank     <= 1'b0;
      pulse_on  <= 1'b0;
      rect_arm  <= 1'b0;
    end else begin
      hyst_mode <= mode_nxt;
      run_cnt   <= run_cnt_nxt;
      blank     <= blank_nxt;
      pulse_on  <= mode_nxt & (out_low | (pulse_on & ~out_high));
      rect_arm  <= mode_nxt & ~out_low & ~sw_pos &
                   (rect_arm | (pulse_on & out_high));
    end
  end

  assign both_off = blank;
  assign hs_req   = ~blank & (hyst_mode ? pulse_on : pwm_req);
  assign ls_req   = ~blank & (hyst_mode ? (rect_arm & ~sw_pos & ~pulse_on)
                                        : ~pwm_req);

endmodule

// File: rtl/pwm_pfm_arbiter_chk.sv
module pwm_pfm_arbiter_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic sw_pos,
  input logic out_dip,
  input logic force_pwm,
  input logic ss_done,
  input logic hyst_mode,
  input logic hs_req,
  input logic ls_req,
  input logic both_off
);

  assert_enter_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hyst_mode && !$past(hyst_mode)) |-> $past(tick && sw_pos && ss_done && !force_pwm));

  assert_leave_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!hyst_mode && $past(hyst_mode)) |-> $past(tick));

  assert_dip_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hyst_mode && tick && out_dip) |=> !hyst_mode);

  assert_force_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hyst_mode && force_pwm) |=> !hyst_mode);

  assert_ss_lock_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hyst_mode && !ss_done) |=> !hyst_mode);

  assert_strobe_on_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hyst_mode) |-> both_off);

  assert_blank_drives_R8: assert property (@(posedge clk) disable iff (!rst_n)
    both_off |-> (!hs_req && !ls_req));

  assert_reverse_block_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hyst_mode && sw_pos) |-> !ls_req);

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req && ls_req));

endmodule

bind pwm_pfm_arbiter pwm_pfm_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sw_pos(sw_pos), .out_dip(out_dip),
  .force_pwm(force_pwm), .ss_done(ss_done), .hyst_mode(hyst_mode),
  .hs_req(hs_req), .ls_req(ls_req), .both_off(both_off)
);

// File: tb/pwm_pfm_arbiter_bench.sv
`timescale 1ns/1ps
module pwm_pfm_arbiter_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, sw_pos = 0, out_dip = 0, out_low = 0, out_high = 0;
  logic force_pwm = 0, ss_done = 1, pwm_req = 0;
  logic hyst_mode, hs_req, ls_req, both_off;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwm_pfm_arbiter #(.RUN_LEN(8)) u_pwm_pfm_arbiter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_pos(sw_pos), .out_dip(out_dip),
    .out_low(out_low), .out_high(out_high), .force_pwm(force_pwm),
    .ss_done(ss_done), .pwm_req(pwm_req), .hyst_mode(hyst_mode),
    .hs_req(hs_req), .ls_req(ls_req), .both_off(both_off)
  );

  // inputs {tick,sw_pos,dip,low,high,force,ss_done,pwm_req} expect {mode,hs,ls,off}
  localparam logic [11:0] VEC [24] = '{
    12'b00000011_0100, 12'b00000010_0010,
    12'b11000010_0010, 12'b11000010_0010, 12'b11000010_0010, 12'b11000010_0010,
    12'b11000010_0010, 12'b11000010_0010, 12'b11000010_0010,
    12'b11000010_1001, 12'b01010010_1001, 12'b11000010_1100,
    12'b00001010_1010, 12'b00000010_1010, 12'b01000010_1000, 12'b00000010_1000,
    12'b10000010_1000, 12'b10000010_1000, 12'b10000010_1000, 12'b10000010_1000,
    12'b10000010_1000, 12'b10000010_1000, 12'b10000010_1000,
    12'b10000011_0100
  };

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b (mode,hs,ls,off)", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] v);
    {tick, sw_pos, out_dip, out_low, out_high, force_pwm, ss_done, pwm_req} = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic pulse_tick(input logic pos, input int n);
    for (int i = 0; i < n; i++) begin
      apply({1'b1, pos, 6'b000010});
      apply({1'b0, pos, 6'b000010});
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    apply(8'b00000010);
    apply(8'b00000010);
    rst_n = 1'b1;
    apply(8'b00000010);
  endtask

  function automatic logic [3:0] outs();
    return {hyst_mode, hs_req, ls_req, both_off};
  endfunction

  initial begin
    @(negedge clk);
    do_reset();
    check("R1 reset state", outs(), 4'b0010);

    for (int i = 0; i < 24; i++) begin
      apply(VEC[i][11:4]);
      check($sformatf("R2/R3/R8/R9/R10/R11 vector %0d", i), outs(), VEC[i][3:0]);
    end

    // R4: opposite sample clears the count
    do_reset();
    pulse_tick(1'b1, 7);
    pulse_tick(1'b0, 1);
    pulse_tick(1'b1, 7);
    check("R4 run restarted", outs(), 4'b0010);
    pulse_tick(1'b1, 1);
    check("R4 fresh run completes", {hyst_mode, 3'b000}, 4'b1000);

    // R11: non-tick samples ignored by the counter
    do_reset();
    pulse_tick(1'b1, 4);
    for (int i = 0; i < 10; i++) apply(8'b00000010);
    pulse_tick(1'b1, 3);
    check("R11 count kept across idle clocks", {hyst_mode, 3'b000}, 4'b0000);
    pulse_tick(1'b1, 1);
    check("R11 eighth tick enters", {hyst_mode, 3'b000}, 4'b1000);

    // R5: dip needs a tick, then exits at once
    pulse_tick(1'b1, 1);
    apply(8'b01100010);
    check("R5 dip without tick", {hyst_mode, 3'b000}, 4'b1000);
    apply(8'b11100010);
    check("R5 dip at tick exits", {hyst_mode, 3'b000}, 4'b0000);

    // R6: forced PWM locks out and exits
    do_reset();
    for (int i = 0; i < 10; i++) begin
      apply(8'b11000110);
      apply(8'b01000110);
    end
    check("R6 forced never enters", {hyst_mode, 3'b000}, 4'b0000);
    pulse_tick(1'b1, 8);
    check("R6 enters after release", {hyst_mode, 3'b000}, 4'b1000);
    apply(8'b01000110);
    check("R6 force waits for tick", {hyst_mode, 3'b000}, 4'b1000);
    apply(8'b11000110);
    check("R6 force exits at tick", {hyst_mode, 3'b000}, 4'b0000);

    // R7: soft-start lockout
    do_reset();
    for (int i = 0; i < 10; i++) begin
      apply(8'b11000000);
      apply(8'b01000000);
    end
    check("R7 soft-start never enters", {hyst_mode, 3'b000}, 4'b0000);
    pulse_tick(1'b1, 8);
    apply(8'b11000000);
    check("R7 soft-start low exits", {hyst_mode, 3'b000}, 4'b0000);

    // R8: blanking ends at the next tick
    do_reset();
    pulse_tick(1'b1, 8);
    check("R8 blank held between ticks", outs(), 4'b1001);
    apply(8'b11000010);
    check("R8 blank released at tick", outs(), 4'b1000);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule